// File: doc/BRIEF.md
# Background Memory Scrubber

This engine sweeps an ECC-protected word memory in the background. It reads one word at a time, passes the stored codeword through a single-error-correcting, double-error-detecting check, and writes the repaired codeword back to the same address only when exactly one bit was wrong. Words that read back clean are never rewritten. Words with uncorrectable damage are left untouched and reported. A programmable wait separates consecutive accesses, so the scrub rate can be traded against memory bandwidth.

The engine shares a synchronous single-port memory with a host. It raises a request and waits for a grant that the external arbiter gives to the host first. It also watches host writes, so a stale repair never overwrites newer host data. Saturating counters of correctable and uncorrectable events, the address of the latest uncorrectable word and a pulse at the end of each pass give the surrounding system what it needs to spot a failing memory early.

Top module: `mem_scrubber`

## Requirements
- R1: Reads are issued to addresses 0, 1, 2, ... up to WORDS-1 in ascending order, then wrap to 0, so every address is read once per pass.
- R2: Codeword layout: bit 0 is even parity over the whole word, bit 2^k holds check bit k, and data bits fill the remaining positions 3, 5, 6, 7, 9, ... in ascending order. A read with exactly one flipped bit, at any of the CODE_W positions, is counted as correctable and the fully corrected codeword is written back to the same address once. A clean word is never written.
- R3: A read whose overall parity is even with a nonzero syndrome, or whose overall parity is odd with a syndrome that points past the last position, is counted as uncorrectable and is never written back.
- R4: The correctable and uncorrectable counters each increase by one per event and hold at 2^CNT_W-1 instead of wrapping.
- R5: `ue_addr` holds the address of the most recent uncorrectable read, and is 0 after reset until the first such event.
- R6: With the grant given at once, the spacing from one read grant to the next is `interval`+4 cycles after a clean word and `interval`+5 cycles after a repaired word.
- R7: While `mem_req` is high and not granted, the request, address, write enable and write data stay unchanged. A host write to another address only delays the write-back.
- R8: A host write to the word under scrub, seen after its read grant and before its write-back grant, cancels that write-back, so the host data survives.
- R9: `sweep_done` is high for exactly one cycle after the last address of each pass has been handled, once per pass.
- R10: During and right after reset, `mem_req`, `sweep_done`, both counters and `ue_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval | input | INTERVAL_W | Idle cycles minus one between scrub accesses |
| mem_req | output | 1 | Scrub access request to the arbiter |
| mem_gnt | input | 1 | Grant; the access happens at the clock edge where it is high with mem_req |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | ADDR_W | Word address of the scrub access |
| mem_wdata | output | CODE_W | Corrected codeword for the write-back |
| mem_rdata | input | CODE_W | Read codeword, valid the cycle after a read grant |
| host_wr_en | input | 1 | Host write taking place this cycle |
| host_wr_addr | input | ADDR_W | Address of that host write |
| ce_count | output | CNT_W | Saturating count of correctable reads |
| ue_count | output | CNT_W | Saturating count of uncorrectable reads |
| ue_addr | output | ADDR_W | Address of the latest uncorrectable read |
| sweep_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
A wrong address pointer shows up at the next read grant as an out-of-order `mem_addr`, and a wrong wrap shows as a missing or doubled `sweep_done` within one pass. A decoder or state fault surfaces as memory contents that differ from the golden image at the end of the pass in which the error was injected, or as a counter value off by one on the cycle after the faulty read. Timing faults in the wait counter or the state sequence change the grant-to-grant spacing, and the bench measures that spacing on every access. Races with host writes are forced on exact cycles, and the bench reads back the host's data after the pass.

// File: rtl/scrub_pkg.sv
// Shared definitions for the memory scrubber.
// Assumes: data widths small enough that check_bits loops a handful of times.
package scrub_pkg;

    // Scrub sequence states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WRITEBACK,
        ST_ADVANCE
    } scrub_state_t;

    // Number of Hamming check bits needed to cover dw data bits.
    function automatic int check_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

endpackage

// File: rtl/secded_check.sv
// Combinational SECDED checker for one stored codeword.
// Layout: bit 0 = overall even parity, bit 2^k = check bit k, data elsewhere.
// Assumes: the codeword was written by a matching encoder; flags are mutually exclusive.
module secded_check #(
    parameter  int DATA_W = 8,
    localparam int PB     = scrub_pkg::check_bits(DATA_W),
    localparam int NPOS   = DATA_W + PB,
    localparam int CODE_W = NPOS + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic              correctable,
    output logic              uncorrectable,
    output logic [CODE_W-1:0] fixed
);

    logic [PB-1:0] syn;
    logic          odd;

    // Syndrome is the XOR of the positions of all set bits.
    always_comb begin
        syn = '0;
        for (int i = 1; i <= NPOS; i++) begin
            if (code[i]) syn = syn ^ PB'(i);
        end
        odd = ^code;
    end

    // Classify and repair: odd parity with a valid position is a single flip.
    always_comb begin
        correctable   = odd && (int'(syn) <= NPOS);
        uncorrectable = (!odd && (syn != '0)) || (odd && (int'(syn) > NPOS));
        fixed         = correctable ? (code ^ (CODE_W'(1) << syn)) : code;
    end

endmodule

// File: rtl/scrub_sat_counter.sv
// Event counter that stops at its all-ones value.
// Assumes: inc is a single-cycle strobe per event.
module scrub_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    logic armed;

    // Count events, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

    // Marks cycles where $past refers to post-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP));

    p_never_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (count >= $past(count)));

endmodule

// File: rtl/mem_scrubber.sv
// Background scrubber: reads each word in turn, repairs single-bit errors by
// writing back the corrected codeword, and logs correctable and uncorrectable
// reads. Assumes a synchronous memory whose read data is valid the cycle after
// the grant, and an arbiter that never grants in a cycle with a host write.
module mem_scrubber
    import scrub_pkg::*;
#(
    parameter  int DATA_W     = 8,
    parameter  int WORDS      = 16,
    parameter  int INTERVAL_W = 8,
    parameter  int CNT_W      = 4,
    localparam int ADDR_W     = $clog2(WORDS),
    localparam int CODE_W     = DATA_W + check_bits(DATA_W) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INTERVAL_W-1:0] interval,
    output logic                  mem_req,
    input  logic                  mem_gnt,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [CODE_W-1:0]     mem_wdata,
    input  logic [CODE_W-1:0]     mem_rdata,
    input  logic                  host_wr_en,
    input  logic [ADDR_W-1:0]     host_wr_addr,
    output logic [CNT_W-1:0]      ce_count,
    output logic [CNT_W-1:0]      ue_count,
    output logic [ADDR_W-1:0]     ue_addr,
    output logic                  sweep_done
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

    scrub_state_t            state, state_nxt;
    logic [INTERVAL_W-1:0]   wait_cnt;
    logic [ADDR_W-1:0]       cur_addr;
    logic [CODE_W-1:0]       wb_word;
    logic                    dec_ce, dec_ue;
    logic [CODE_W-1:0]       dec_fixed;
    logic                    host_hit, at_last, armed;

    secded_check #(.DATA_W(DATA_W)) u_check (
        .code          (mem_rdata),
        .correctable   (dec_ce),
        .uncorrectable (dec_ue),
        .fixed         (dec_fixed)
    );

    scrub_sat_counter #(.W(CNT_W)) u_ce_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (state == ST_CHECK && dec_ce),
        .count (ce_count)
    );

    scrub_sat_counter #(.W(CNT_W)) u_ue_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (state == ST_CHECK && dec_ue),
        .count (ue_count)
    );

    // Host write to the word currently being scrubbed.
    assign host_hit = host_wr_en && (host_wr_addr == cur_addr);
    assign at_last  = (cur_addr == LAST);

    // Next-state selection for the scrub sequence.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE:      if (wait_cnt >= interval) state_nxt = ST_READ;
            ST_READ:      if (mem_gnt) state_nxt = ST_CHECK;
            ST_CHECK:     state_nxt = (dec_ce && !host_hit) ? ST_WRITEBACK : ST_ADVANCE;
            ST_WRITEBACK: if (host_hit || mem_gnt) state_nxt = ST_ADVANCE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Inter-access wait counter, running only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_IDLE || wait_cnt >= interval) wait_cnt <= '0;
        else                                                    wait_cnt <= wait_cnt + 1'b1;
    end

    // Sweep pointer with wrap, and the end-of-pass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            sweep_done <= 1'b0;
        end else begin
            sweep_done <= (state == ST_ADVANCE) && at_last;
            if (state == ST_ADVANCE) cur_addr <= at_last ? '0 : cur_addr + 1'b1;
        end
    end

    // Capture the repaired word and the address of the latest uncorrectable read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_word <= '0;
            ue_addr <= '0;
        end else if (state == ST_CHECK) begin
            wb_word <= dec_fixed;
            if (dec_ue) ue_addr <= cur_addr;
        end
    end

    // Memory port drive; the write-back request is withdrawn on a host hit.
    assign mem_req   = (state == ST_READ) || (state == ST_WRITEBACK && !host_hit);
    assign mem_we    = (state == ST_WRITEBACK);
    assign mem_addr  = cur_addr;
    assign mem_wdata = wb_word;

    // Qualifies $past-based checks after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADVANCE && at_last) |=> (mem_addr == '0));

    p_no_writeback_on_ue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && dec_ue) |=> !mem_we);

    p_request_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mem_req && !mem_gnt && !host_hit) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_host_cancels_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CHECK || mem_we) && host_hit) |=> !mem_we);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

endmodule

// File: tb/tb_mem_scrubber.sv
`timescale 1ns/1ps
// Bench: golden memory image, host-first arbiter, pass-by-pass error injection.
module tb_mem_scrubber;

    localparam int DW = 8;
    localparam int CW = 13;
    localparam int WORDS = 16;
    localparam int AW = 4;
    localparam int IW = 8;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] interval = 8'd2;
    logic          mem_req, mem_gnt, mem_we;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] mem_wdata;
    logic [CW-1:0] mem_rdata = '0;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [CW-1:0] host_wr_data = '0;
    logic [NW-1:0] ce_count, ue_count;
    logic [AW-1:0] ue_addr;
    logic          sweep_done;

    int n_checks = 0;
    int n_err = 0;

    logic [CW-1:0] mem  [WORDS];
    logic [CW-1:0] gold [WORDS];

    int wr_cnt [WORDS];
    int per_at [WORDS];
    int cyc = 0, last_rd = 0, have_last = 0;
    int rd_expect = 0, rd_order_err = 0, rd_in_sweep = 0;
    int pulses = 0, pulse_err = 0, prev_sd = 0;

    always #2.5 clk = ~clk;

    mem_scrubber #(.DATA_W(DW), .WORDS(WORDS), .INTERVAL_W(IW), .CNT_W(NW)) dut (
        .clk(clk), .rst_n(rst_n), .interval(interval),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
        .ce_count(ce_count), .ue_count(ue_count), .ue_addr(ue_addr),
        .sweep_done(sweep_done)
    );

    // Host has priority: no scrub grant in a host write cycle.
    assign mem_gnt = mem_req && !host_wr_en;

    // Memory model: synchronous, read data one cycle after grant.
    always @(posedge clk) begin
        if (host_wr_en) mem[host_wr_addr] <= host_wr_data;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // Port monitor, sampled well after the driving negedge.
    always @(negedge clk) begin
        #0.5;
        cyc++;
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (mem_we) wr_cnt[mem_addr]++;
                else begin
                    if (int'(mem_addr) != rd_expect) rd_order_err++;
                    rd_expect = (rd_expect + 1) % WORDS;
                    rd_in_sweep++;
                    if (have_last != 0) per_at[mem_addr] = cyc - last_rd;
                    last_rd = cyc;
                    have_last = 1;
                end
            end
            if (sweep_done) begin
                pulses++;
                if (prev_sd != 0) pulse_err++;
            end
            prev_sd = int'(sweep_done);
        end
    end

    // Reference encoder written from the layout in R2.
    function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 4; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p < CW; p++) if (((p >> k) & 1) != 0) par ^= c[p];
            c[1 << k] = par;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_sweep();
        do @(negedge clk); while (!sweep_done);
        #1;
    endtask

    task automatic start_pass();
        rd_in_sweep = 0;
        rd_order_err = 0;
        have_last = 0;
        for (int w = 0; w < WORDS; w++) begin
            wr_cnt[w] = 0;
            per_at[w] = 0;
        end
    endtask

    task automatic compare_mem(input string tag);
        for (int w = 0; w < WORDS; w++) check_eq(tag, int'(mem[w]), int'(gold[w]));
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [CW-1:0] d);
        host_wr_en = 1'b1;
        host_wr_addr = a;
        host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int total_wr;
        for (int w = 0; w < WORDS; w++) begin
            gold[w] = enc(DW'(w * 29 + 7));
            mem[w]  = gold[w];
        end
        start_pass();
        repeat (4) @(negedge clk);
        // R10: reset state
        check_eq("R10 mem_req", int'(mem_req), 0);
        check_eq("R10 ce_count", int'(ce_count), 0);
        check_eq("R10 ue_count", int'(ue_count), 0);
        check_eq("R10 ue_addr", int'(ue_addr), 0);
        check_eq("R10 sweep_done", int'(sweep_done), 0);
        rst_n = 1'b1;

        // Pass 1: clean memory
        wait_sweep();
        check_eq("R1 reads per pass", rd_in_sweep, WORDS);
        check_eq("R1 read order", rd_order_err, 0);
        total_wr = 0;
        for (int w = 0; w < WORDS; w++) total_wr += wr_cnt[w];
        check_eq("R2 no writes on clean words", total_wr, 0);
        check_eq("R2 clean ce_count", int'(ce_count), 0);
        compare_mem("R2 clean image");

        // Pass 2: a few single-bit errors, data and check positions
        start_pass();
        mem[1]  = gold[1]  ^ (CW'(1) << 0);
        mem[4]  = gold[4]  ^ (CW'(1) << 2);
        mem[7]  = gold[7]  ^ (CW'(1) << 5);
        mem[11] = gold[11] ^ (CW'(1) << 8);
        mem[15] = gold[15] ^ (CW'(1) << 12);
        wait_sweep();
        check_eq("R2 ce_count after five", int'(ce_count), 5);
        check_eq("R2 write-back at 1", wr_cnt[1], 1);
        check_eq("R2 write-back at 15", wr_cnt[15], 1);
        check_eq("R2 no write at 0", wr_cnt[0], 0);
        check_eq("R5 ue_addr still zero", int'(ue_addr), 0);
        check_eq("R1 reads per pass 2", rd_in_sweep, WORDS);
        compare_mem("R2 repaired image");

        // Pass 3: zero interval, spacing of clean words
        interval = 8'd0;
        start_pass();
        wait_sweep();
        for (int w = 1; w < WORDS; w++) check_eq("R6 spacing interval 0", per_at[w], 4);

        // Pass 4: every bit position flipped once; counter saturates
        interval = 8'd5;
        start_pass();
        for (int w = 0; w < CW; w++) mem[w] = gold[w] ^ (CW'(1) << w);
        wait_sweep();
        for (int w = 1; w <= CW; w++) check_eq("R6 spacing after repair", per_at[w], 10);
        for (int w = CW + 1; w < WORDS; w++) check_eq("R6 spacing after clean", per_at[w], 9);
        check_eq("R4 ce_count saturated", int'(ce_count), 15);
        compare_mem("R2 all positions repaired");

        // Pass 5: uncorrectable words
        interval = 8'd1;
        start_pass();
        mem[3]  = gold[3]  ^ (CW'(1) << 1) ^ (CW'(1) << 5);
        mem[9]  = gold[9]  ^ (CW'(1) << 0) ^ (CW'(1) << 7);
        mem[12] = gold[12] ^ (CW'(1) << 1) ^ (CW'(1) << 4) ^ (CW'(1) << 8);
        wait_sweep();
        check_eq("R3 ue_count", int'(ue_count), 3);
        check_eq("R5 ue_addr latest", int'(ue_addr), 12);
        check_eq("R4 ce_count held", int'(ce_count), 15);
        total_wr = 0;
        for (int w = 0; w < WORDS; w++) total_wr += wr_cnt[w];
        check_eq("R3 no write-back", total_wr, 0);
        check_eq("R3 word 3 untouched", int'(mem[3]), int'(gold[3] ^ (CW'(1) << 1) ^ (CW'(1) << 5)));
        check_eq("R3 word 12 untouched", int'(mem[12]),
                 int'(gold[12] ^ (CW'(1) << 1) ^ (CW'(1) << 4) ^ (CW'(1) << 8)));
        mem[3] = gold[3];
        mem[9] = gold[9];
        mem[12] = gold[12];

        // Pass 6: host write races
        start_pass();
        mem[6]  = gold[6]  ^ (CW'(1) << 3);
        mem[10] = gold[10] ^ (CW'(1) << 10);
        mem[14] = gold[14] ^ (CW'(1) << 6);
        fork
            begin
                do @(negedge clk); while (!(mem_req && mem_gnt && !mem_we && mem_addr == 4'd6));
                @(negedge clk);
                host_write(4'd6, enc(8'hA5));
            end
            begin
                do @(negedge clk); while (!(mem_req && mem_we && mem_addr == 4'd10));
                host_write(4'd10, enc(8'h3C));
            end
            begin
                do @(negedge clk); while (!(mem_req && mem_we && mem_addr == 4'd14));
                host_write(4'd2, enc(8'h5A));
            end
            wait_sweep();
        join
        gold[6]  = enc(8'hA5);
        gold[10] = enc(8'h3C);
        gold[2]  = enc(8'h5A);
        check_eq("R8 cancel in check cycle", wr_cnt[6], 0);
        check_eq("R8 cancel while waiting", wr_cnt[10], 0);
        check_eq("R7 delayed write-back done", wr_cnt[14], 1);
        check_eq("R8 host data kept at 6", int'(mem[6]), int'(gold[6]));
        check_eq("R8 host data kept at 10", int'(mem[10]), int'(gold[10]));
        check_eq("R7 host write elsewhere", int'(mem[2]), int'(gold[2]));
        check_eq("R3 ue_count unchanged", int'(ue_count), 3);
        compare_mem("R7 final image");

        // R9: one pulse per pass, never two cycles long
        check_eq("R9 pulse count", pulses, 6);
        check_eq("R9 pulse width", pulse_err, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule